// File: doc/BRIEF.md
# Buffered I2C Master Block Sequencer

This block sequences an I2C master that moves whole blocks of bytes per host command. The host sets a byte count and a last-byte flag, fills a circular byte buffer through a write port, and then writes control bits. A control write with the start bit makes the sequencer issue a START. It then raises its interrupt flag with a status code. The next plain control write clears the flag and runs a block. The first buffer byte after a START is the slave address with the R/W bit in bit 0. Bit 0 = 0 selects a write, and the block sends buffer bytes from index 0 upward. Bit 0 = 1 selects a read: the block sends the address and then receives the counted number of bytes into the buffer from index 0, where the host pops them through a read port.

At the end of every block the flag rises again with a status code, and the transfer count output shows how many bytes went over the bus. Blocks may follow one another without a new START until the host asks for a STOP or a repeated START. Bit timing on SCL and SDA is not part of this block. A byte-level engine performs the bus work and answers each request with a done pulse.

Top module: `i2cbuf_master`

## Requirements
- R1: After reset the flag `si` is 0, `status` is F8h, `xfer_count` is 0 and `eng_req` is 0.
- R2: A count write is accepted only when `cnt_val` is between 1 and DEPTH; any other value leaves both the count and the last-byte flag unchanged.
- R3: The host buffer write pointer advances by one per write and wraps, so write number DEPTH+1 after a rewind lands at index 0. Both host pointers rewind to 0 each time `si` rises.
- R4: A control write with `ctl_mode`=1 and `ctl_sta`=1 while idle requests a START (`eng_op`=0); when the engine finishes, `si` rises with status 08h.
- R5: While `si` is 1, a control write with `ctl_mode`=1, `ctl_sta`=0 and `ctl_sto`=0 clears `si` and starts a block. A write block sends exactly the programmed count of bytes (`eng_op`=2) from buffer index 0 upward, whatever number of bytes were loaded. After a START the first of these bytes is the address.
- R6: A write block that ends with every byte acknowledged raises `si` with status 28h, and `xfer_count` equals the count.
- R7: A NACK on a written byte ends the block at once with status 30h. `xfer_count` includes the refused byte.
- R8: When buffer byte 0 has bit 0 set after a START, it is sent as the address and is not counted. The block then makes count read requests (`eng_op`=3), stores the bytes from index 0 in order for the host read port, and ends with status 50h (flag clear) or 58h (flag set).
- R9: On reads, `eng_ack` is 1 for every byte except the last byte of a block whose last-byte flag (`cnt_lb`) was 1, where it is 0.
- R10: A NACK on a read address ends the block with status 48h and `xfer_count` 0.
- R11: Further blocks run without a new START. A control write with `ctl_sto`=1 while `si` is 1 requests a STOP (`eng_op`=1), after which `si` is 0 and status is F8h.
- R12: Control writes with `ctl_mode`=0, and control writes while a block is running, have no effect.
- R13: A control write with `ctl_sta`=1 while `si` is 1 issues a repeated START, returns status 08h, and takes the next block's address from buffer index 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_we | input | 1 | Count register write strobe |
| cnt_val | input | CW | Byte count for the next block |
| cnt_lb | input | 1 | Last-byte flag: 1 means NACK the final received byte |
| buf_we | input | 1 | Buffer write strobe |
| buf_wdata | input | 8 | Buffer write data |
| buf_re | input | 1 | Buffer read pop strobe |
| buf_rdata | output | 8 | Byte at the host read pointer |
| ctl_we | input | 1 | Control write strobe |
| ctl_sta | input | 1 | Start / repeated start request |
| ctl_sto | input | 1 | Stop request |
| ctl_mode | input | 1 | Must be 1 for a control write to act |
| si | output | 1 | Interrupt flag, waiting for the host |
| status | output | 8 | Status code |
| xfer_count | output | CW | Bytes moved in the last block |
| eng_req | output | 1 | Request to byte engine, held until done |
| eng_op | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| eng_wdata | output | 8 | Byte to send |
| eng_ack | output | 1 | Acknowledge to return on a read |
| eng_done | input | 1 | Engine finished the request |
| eng_nack | input | 1 | Slave refused a written byte |
| eng_rdata | input | 8 | Byte received on a read |

## Verification
The bench builds the block with the default depth of 68. At that depth the count field is 7 bits wide, so a count of 69 can be written and is shown to be rejected, and the wrap on the 69th buffer write can be observed as a changed address byte. A byte-engine model with a fixed latency logs every request, refuses chosen bytes and returns index-coded read data. This allows checks of partial counts, ACK placement on the last byte, and back-to-back blocks that pick up stale buffer contents.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } eng_op_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_HOLD,
      S_XFER,
      S_STOP
   } seq_state_t;

   localparam logic [7:0] ST_IDLE         = 8'hF8;
   localparam logic [7:0] ST_STARTED      = 8'h08;
   localparam logic [7:0] ST_TX_DONE      = 8'h28;
   localparam logic [7:0] ST_TX_NACK      = 8'h30;
   localparam logic [7:0] ST_RX_ADDR_NACK = 8'h48;
   localparam logic [7:0] ST_RX_MORE      = 8'h50;
   localparam logic [7:0] ST_RX_LAST      = 8'h58;

endpackage

// File: rtl/i2cbuf_ring.sv
module i2cbuf_ring #(
   parameter int DEPTH = 68,
   parameter int DW    = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rewind,
   input  logic          h_we,
   input  logic [DW-1:0] h_wdata,
   input  logic          h_re,
   output logic [DW-1:0] h_rdata,
   input  logic [IW-1:0] e_idx,
   input  logic          e_we,
   input  logic [DW-1:0] e_wdata,
   output logic [DW-1:0] e_rdata,
   output logic [DW-1:0] mem0
);

   logic [DW-1:0] mem [DEPTH];
   logic [IW-1:0] hw_ptr, hr_ptr, hw_nxt, hr_nxt;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("i2cbuf_ring: DEPTH must be at least 2");
      end
      if ((1 << IW) == DEPTH) begin : g_pow2
         assign hw_nxt = hw_ptr + 1'b1;
         assign hr_nxt = hr_ptr + 1'b1;
      end else begin : g_mod
         assign hw_nxt = (hw_ptr == IW'(DEPTH - 1)) ? '0 : hw_ptr + 1'b1;
         assign hr_nxt = (hr_ptr == IW'(DEPTH - 1)) ? '0 : hr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw_ptr <= '0;
         hr_ptr <= '0;
      end else begin
         if (rewind)    hw_ptr <= '0;
         else if (h_we) hw_ptr <= hw_nxt;
         if (rewind)    hr_ptr <= '0;
         else if (h_re) hr_ptr <= hr_nxt;
      end
   end

   // engine receive write wins over a host write to the same slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (e_we) mem[e_idx] <= e_wdata;
         if (h_we && !(e_we && (e_idx == hw_ptr))) mem[hw_ptr] <= h_wdata;
      end
   end

   assign h_rdata = mem[hr_ptr];
   assign e_rdata = mem[e_idx];
   assign mem0    = mem[0];

   p_wptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_ptr < IW'(DEPTH)) && (hr_ptr < IW'(DEPTH)));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we && !rewind && (hw_ptr == IW'(DEPTH - 1))) |=> (hw_ptr == '0));

endmodule

// File: rtl/i2cbuf_seq.sv
module i2cbuf_seq
   import i2cbuf_pkg::*;
#(
   parameter int DEPTH = 68,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_we,
   input  logic [CW-1:0] cnt_val,
   input  logic          cnt_lb,
   input  logic          ctl_we,
   input  logic          ctl_sta,
   input  logic          ctl_sto,
   input  logic          ctl_mode,
   output logic          si,
   output logic [7:0]    status,
   output logic [CW-1:0] xfer_count,
   output logic          eng_req,
   output logic [1:0]    eng_op,
   output logic [7:0]    eng_wdata,
   output logic          eng_ack,
   input  logic          eng_done,
   input  logic          eng_nack,
   input  logic [7:0]    eng_rdata,
   output logic [IW-1:0] e_idx,
   output logic          e_we,
   output logic [7:0]    e_wdata,
   input  logic [7:0]    e_rdata,
   input  logic [7:0]    mem0,
   output logic          rewind
);

   seq_state_t    state;
   logic [CW-1:0] bc, left, cnt;
   logic          lb, blk_lb, addr_pend, dir_rd;
   logic [IW-1:0] idx, idx_nxt;
   logic          ctl_ok, addr_rd_phase, xfer_rd, blk_end, cnt_ok;

   assign ctl_ok        = ctl_we && ctl_mode;
   assign cnt_ok        = cnt_we && (cnt_val != '0) && (cnt_val <= CW'(DEPTH));
   assign addr_rd_phase = addr_pend && mem0[0];
   assign xfer_rd       = !addr_pend && dir_rd;
   assign idx_nxt       = (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;

   always_comb begin
      if (addr_rd_phase) blk_end = eng_nack;
      else if (xfer_rd)  blk_end = (left == CW'(1));
      else               blk_end = eng_nack || (left == CW'(1));
   end

   assign eng_req = (state == S_START) || (state == S_XFER) || (state == S_STOP);
   always_comb begin
      unique case (state)
         S_START: eng_op = OP_START;
         S_STOP:  eng_op = OP_STOP;
         default: eng_op = xfer_rd ? OP_READ : OP_WRITE;
      endcase
   end
   assign eng_wdata  = addr_rd_phase ? mem0 : e_rdata;
   assign eng_ack    = !(blk_lb && (left == CW'(1)));
   assign e_idx      = idx;
   assign e_we       = (state == S_XFER) && eng_done && xfer_rd;
   assign e_wdata    = eng_rdata;
   assign rewind     = eng_done && ((state == S_START) || ((state == S_XFER) && blk_end));
   assign xfer_count = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         bc        <= CW'(1);
         lb        <= 1'b0;
         blk_lb    <= 1'b0;
         left      <= '0;
         cnt       <= '0;
         idx       <= '0;
         addr_pend <= 1'b0;
         dir_rd    <= 1'b0;
         si        <= 1'b0;
         status    <= ST_IDLE;
      end else begin
         if (cnt_ok) begin
            bc <= cnt_val;
            lb <= cnt_lb;
         end
         unique case (state)
            S_IDLE: if (ctl_ok && ctl_sta) state <= S_START;
            S_START: if (eng_done) begin
               state     <= S_HOLD;
               si        <= 1'b1;
               status    <= ST_STARTED;
               addr_pend <= 1'b1;
            end
            S_HOLD: if (ctl_ok) begin
               si <= 1'b0;
               if (ctl_sto)      state <= S_STOP;
               else if (ctl_sta) state <= S_START;
               else begin
                  state  <= S_XFER;
                  left   <= bc;
                  blk_lb <= lb;
                  cnt    <= '0;
                  idx    <= '0;
               end
            end
            S_XFER: if (eng_done) begin
               if (addr_rd_phase) begin
                  addr_pend <= 1'b0;
                  dir_rd    <= 1'b1;
                  if (blk_end) status <= ST_RX_ADDR_NACK;
               end else begin
                  if (!xfer_rd) begin
                     addr_pend <= 1'b0;
                     dir_rd    <= 1'b0;
                  end
                  cnt  <= cnt + 1'b1;
                  idx  <= idx_nxt;
                  left <= left - 1'b1;
                  if (xfer_rd)       status <= blk_lb ? ST_RX_LAST : ST_RX_MORE;
                  else if (eng_nack) status <= ST_TX_NACK;
                  else               status <= ST_TX_DONE;
               end
               if (blk_end) begin
                  state <= S_HOLD;
                  si    <= 1'b1;
               end
            end
            S_STOP: if (eng_done) begin
               state     <= S_IDLE;
               status    <= ST_IDLE;
               addr_pend <= 1'b0;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata) && $stable(eng_ack)));

   p_si_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(si) |-> (status != ST_IDLE));

   p_bc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bc != '0) && (bc <= CW'(DEPTH)));

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_count <= CW'(DEPTH));

   p_nack_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_XFER) && eng_done && !addr_pend && !dir_rd && eng_nack)
      |=> (si && (status == ST_TX_NACK)));

   p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_STOP) && eng_done) |=> (!si && (status == ST_IDLE)));

   p_mode_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (si && ctl_we && !ctl_mode) |=> si);

endmodule

// File: rtl/i2cbuf_master.sv
module i2cbuf_master
   import i2cbuf_pkg::*;
#(
   parameter int DEPTH = 68,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_we,
   input  logic [CW-1:0] cnt_val,
   input  logic          cnt_lb,
   input  logic          buf_we,
   input  logic [7:0]    buf_wdata,
   input  logic          buf_re,
   output logic [7:0]    buf_rdata,
   input  logic          ctl_we,
   input  logic          ctl_sta,
   input  logic          ctl_sto,
   input  logic          ctl_mode,
   output logic          si,
   output logic [7:0]    status,
   output logic [CW-1:0] xfer_count,
   output logic          eng_req,
   output logic [1:0]    eng_op,
   output logic [7:0]    eng_wdata,
   output logic          eng_ack,
   input  logic          eng_done,
   input  logic          eng_nack,
   input  logic [7:0]    eng_rdata
);

   logic [IW-1:0] e_idx;
   logic          e_we, rewind;
   logic [7:0]    e_wdata, e_rdata, mem0;

   i2cbuf_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .rewind  (rewind),
      .h_we    (buf_we),
      .h_wdata (buf_wdata),
      .h_re    (buf_re),
      .h_rdata (buf_rdata),
      .e_idx   (e_idx),
      .e_we    (e_we),
      .e_wdata (e_wdata),
      .e_rdata (e_rdata),
      .mem0    (mem0)
   );

   i2cbuf_seq #(.DEPTH(DEPTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_we     (cnt_we),
      .cnt_val    (cnt_val),
      .cnt_lb     (cnt_lb),
      .ctl_we     (ctl_we),
      .ctl_sta    (ctl_sta),
      .ctl_sto    (ctl_sto),
      .ctl_mode   (ctl_mode),
      .si         (si),
      .status     (status),
      .xfer_count (xfer_count),
      .eng_req    (eng_req),
      .eng_op     (eng_op),
      .eng_wdata  (eng_wdata),
      .eng_ack    (eng_ack),
      .eng_done   (eng_done),
      .eng_nack   (eng_nack),
      .eng_rdata  (eng_rdata),
      .e_idx      (e_idx),
      .e_we       (e_we),
      .e_wdata    (e_wdata),
      .e_rdata    (e_rdata),
      .mem0       (mem0),
      .rewind     (rewind)
   );

endmodule

// File: tb/tb_i2cbuf_master.sv
module tb_i2cbuf_master;

   localparam int DEPTH = 68;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cnt_we = 1'b0, cnt_lb = 1'b0;
   logic [CW-1:0] cnt_val = '0;
   logic          buf_we = 1'b0, buf_re = 1'b0;
   logic [7:0]    buf_wdata = '0, buf_rdata;
   logic          ctl_we = 1'b0, ctl_sta = 1'b0, ctl_sto = 1'b0, ctl_mode = 1'b0;
   logic          si;
   logic [7:0]    status;
   logic [CW-1:0] xfer_count;
   logic          eng_req, eng_ack;
   logic [1:0]    eng_op;
   logic [7:0]    eng_wdata;
   logic          eng_done, eng_nack;
   logic [7:0]    eng_rdata;

   int total = 0, bad = 0;

   always #5 clk = ~clk;

   i2cbuf_master #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .cnt_we(cnt_we), .cnt_val(cnt_val), .cnt_lb(cnt_lb),
      .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_re(buf_re), .buf_rdata(buf_rdata),
      .ctl_we(ctl_we), .ctl_sta(ctl_sta), .ctl_sto(ctl_sto), .ctl_mode(ctl_mode),
      .si(si), .status(status), .xfer_count(xfer_count),
      .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
      .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
   );

   // byte engine model: logs each request, answers after a fixed latency
   logic [1:0] log_op   [512];
   logic [7:0] log_data [512];
   logic       log_ack  [512];
   int log_n = 0, nack_at = -1, cur = 0, tmr = 0;
   bit busy = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         eng_done  <= 1'b0;
         eng_nack  <= 1'b0;
         eng_rdata <= 8'h00;
         busy      <= 1'b0;
      end else begin
         eng_done <= 1'b0;
         if (busy) begin
            if (tmr == 0) begin
               eng_done  <= 1'b1;
               busy      <= 1'b0;
               eng_nack  <= (cur == nack_at);
               eng_rdata <= 8'(8'h40 + cur);
            end else tmr <= tmr - 1;
         end else if (eng_req && !eng_done) begin
            busy            <= 1'b1;
            tmr             <= 2;
            cur             <= log_n;
            log_op[log_n]   <= eng_op;
            log_data[log_n] <= eng_wdata;
            log_ack[log_n]  <= eng_ack;
            log_n           <= log_n + 1;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic set_count(input int n, input bit lb);
      @(negedge clk); cnt_we = 1'b1; cnt_val = CW'(n); cnt_lb = lb;
      @(negedge clk); cnt_we = 1'b0;
   endtask

   task automatic load(input logic [7:0] b);
      @(negedge clk); buf_we = 1'b1; buf_wdata = b;
      @(negedge clk); buf_we = 1'b0;
   endtask

   task automatic pop(output logic [7:0] b);
      @(negedge clk); b = buf_rdata; buf_re = 1'b1;
      @(negedge clk); buf_re = 1'b0;
   endtask

   task automatic ctl(input bit sta, input bit sto, input bit mode);
      @(negedge clk); ctl_we = 1'b1; ctl_sta = sta; ctl_sto = sto; ctl_mode = mode;
      @(negedge clk); ctl_we = 1'b0; ctl_sta = 1'b0; ctl_sto = 1'b0; ctl_mode = 1'b0;
   endtask

   task automatic wait_si();
      for (int n = 0; n < 2000 && !si; n++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 2000 && status != 8'hF8; n++) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 si", si, 0);
      chk("R1 status", status, 8'hF8);
      chk("R1 count", xfer_count, 0);
      chk("R1 eng_req", eng_req, 0);
   endtask

   task automatic t_write_block();
      logic [7:0] d[7] = '{8'h50, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
      int ln;
      set_count(5, 0);
      set_count(0, 0);
      set_count(69, 0);
      for (int k = 0; k < 7; k++) load(d[k]);
      ln = log_n;
      ctl(1, 0, 1);
      wait_si();
      chk("R4 status", status, 8'h08);
      chk("R4 start op", log_op[ln], 0);
      chk("R4 log", log_n, ln + 1);
      ctl(0, 0, 1);
      ctl(0, 1, 1);
      wait_si();
      chk("R6 R12 status", status, 8'h28);
      chk("R6 R2 count", xfer_count, 5);
      chk("R5 R2 bytes", log_n, ln + 6);
      for (int k = 0; k < 5; k++) begin
         chk("R5 op", log_op[ln + 1 + k], 2);
         chk("R5 data", log_data[ln + 1 + k], d[k]);
      end
   endtask

   task automatic t_back_to_back();
      int ln;
      set_count(3, 0);
      load(8'h77);
      load(8'h88);
      ln = log_n;
      ctl(0, 0, 1);
      wait_si();
      chk("R11 status", status, 8'h28);
      chk("R5 count", xfer_count, 3);
      chk("R11 no start", log_op[ln], 2);
      chk("R5 d0", log_data[ln], 8'h77);
      chk("R5 d1", log_data[ln + 1], 8'h88);
      chk("R5 stale d2", log_data[ln + 2], 8'h22);
   endtask

   task automatic t_mode_zero();
      int ln = log_n;
      ctl(0, 1, 0);
      repeat (10) @(negedge clk);
      chk("R12 si", si, 1);
      chk("R12 status", status, 8'h28);
      chk("R12 no req", log_n, ln);
   endtask

   task automatic t_nack();
      int ln;
      set_count(4, 0);
      ln = log_n;
      nack_at = ln + 1;
      ctl(0, 0, 1);
      wait_si();
      nack_at = -1;
      chk("R7 status", status, 8'h30);
      chk("R7 count", xfer_count, 2);
      chk("R7 aborted", log_n, ln + 2);
   endtask

   task automatic t_stop();
      ctl(0, 1, 1);
      wait_idle();
      chk("R11 stop op", log_op[log_n - 1], 1);
      chk("R11 si", si, 0);
      chk("R11 status", status, 8'hF8);
   endtask

   task automatic t_wrap();
      for (int k = 0; k < DEPTH + 1; k++) load((k == DEPTH) ? 8'hE0 : 8'(k + 1));
      set_count(1, 0);
      ctl(1, 0, 1);
      wait_si();
      ctl(0, 0, 1);
      wait_si();
      chk("R3 wrapped byte", log_data[log_n - 1], 8'hE0);
      chk("R3 count", xfer_count, 1);
      t_stop();
   endtask

   task automatic t_read();
      int ln;
      logic [7:0] b;
      load(8'hA1);
      set_count(3, 0);
      ln = log_n;
      ctl(1, 0, 1);
      wait_si();
      ctl(0, 0, 1);
      wait_si();
      chk("R8 addr op", log_op[ln + 1], 2);
      chk("R8 addr", log_data[ln + 1], 8'hA1);
      chk("R8 status", status, 8'h50);
      chk("R8 count", xfer_count, 3);
      for (int k = 0; k < 3; k++) begin
         chk("R8 rd op", log_op[ln + 2 + k], 3);
         chk("R9 ack", log_ack[ln + 2 + k], 1);
      end
      for (int k = 0; k < 3; k++) begin
         pop(b);
         chk("R8 rd data", b, 8'h40 + ln + 2 + k);
      end
      set_count(2, 1);
      ln = log_n;
      ctl(0, 0, 1);
      wait_si();
      chk("R9 status", status, 8'h58);
      chk("R9 count", xfer_count, 2);
      chk("R9 first ack", log_ack[ln], 1);
      chk("R9 last nack", log_ack[ln + 1], 0);
      chk("R11 no start", log_op[ln], 3);
   endtask

   task automatic t_restart();
      int ln = log_n;
      ctl(1, 0, 1);
      wait_si();
      chk("R13 start op", log_op[ln], 0);
      chk("R13 status", status, 8'h08);
      load(8'h33);
      set_count(2, 0);
      nack_at = log_n;
      ln = log_n;
      ctl(0, 0, 1);
      wait_si();
      nack_at = -1;
      chk("R13 addr", log_data[ln], 8'h33);
      chk("R10 status", status, 8'h48);
      chk("R10 count", xfer_count, 0);
      chk("R10 one req", log_n, ln + 1);
      t_stop();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_block();
      t_back_to_back();
      t_mode_zero();
      t_nack();
      t_stop();
      t_wrap();
      t_read();
      t_restart();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule